// File: doc/BRIEF.md
# Quantized PFM Switch Timing Generator

This block times the two power switches of a pulse-frequency-modulated boost converter. A 4-bit control word chooses the switching period from a quantized, roughly geometric set. The period is built from a short stepped base count multiplied by a power-of-two prescale. The low-side gate is driven high for the first half of the period, so the waveform has a 50% duty cycle. When that half ends, the active-low high-side gate is pulled low for exactly one clock. The clock after that, a one-clock done strobe is raised for the zero-crossing sampler.

Both gates are timed by the same clock. The low-side on-time is therefore always an exact whole multiple of the high-side on-time. A cycle is started only by the regulation request. Once it has begun it always runs through both halves, even if the request drops. The control word is captured when a cycle starts, so a change to the word never alters a cycle that is already under way. If the request is still high at the end of the low half, the next cycle follows with no gap.

Top module: `pfm_gate_timer`

## Requirements
- R1: With the request held high, the low-side gate stays low for as many clocks as it was high, so consecutive cycles run back to back at a 50% duty cycle.
- R2: The low-side on-time in clocks is (4 + s[1:0]) * 2^s[3:2], where s is the bitwise inverse of the control word. For example, word 14 gives 5 clocks and word 5 gives 24 clocks.
- R3: At the ends of the range, word 15 gives a 4-clock on-time (period 8) and word 0 gives a 56-clock on-time (period 112).
- R4: The high-side gate goes low in the same clock in which the low-side gate falls. It stays low for exactly one clock.
- R5: From idle, no cycle starts while the request is low. The low-side gate rises on the first clock edge at which the request is sampled high.
- R6: A started cycle completes its full on-half and off-half even if the request drops partway through.
- R7: The control word is captured at the clock edge that starts a cycle. Changes to it during the cycle do not change that cycle's timing.
- R8: The done output is high for exactly one clock, the clock that follows the high-side pulse.
- R9: While reset is asserted, the low-side gate is low, the high-side gate is high (inactive) and done is low.
- R10: The low-side gate and the active high-side gate are never on in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Regulation request; high asks for switching cycles |
| ctrl | input | 4 | Period control word; a larger value gives a shorter period |
| lo_gate | output | 1 | Low-side switch gate, active high |
| hi_gate_n | output | 1 | High-side switch gate, active low |
| cyc_done | output | 1 | One-clock strobe after the high-side pulse |

## Verification
The bound checker watches, on every clock, the relations between the outputs. It checks that the two gates are never on together and that the high-side pulse starts exactly when the low-side gate falls and lasts one clock. It also checks that done follows that pulse by one clock and that every low-side rise is preceded by a sampled request. The lengths of the on-half and off-half for each control word cannot be seen by such local properties. Neither can the capture of the word at cycle start or the completion of a cycle after the request is withdrawn. The bench's vector table and directed scenarios measure those by counting clocks.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ON   = 2'd1,
      PH_OFF  = 2'd2
   } phase_t;
endpackage

// File: rtl/pfm_word_decode.sv
module pfm_word_decode #(
   parameter int STEP_BITS     = 2,
   parameter int DIV_BITS      = 2,
   parameter int BASE_MIN_HALF = 4,
   parameter bit INVERT        = 1'b1,
   localparam int CW = STEP_BITS + DIV_BITS,
   localparam int HW = $clog2(BASE_MIN_HALF + (2 ** STEP_BITS))
) (
   input  logic [CW-1:0]       word_i,
   output logic [HW-1:0]       half_o,
   output logic [DIV_BITS-1:0] shift_o
);
   logic [CW-1:0] sel;

   generate
      if (INVERT) begin : g_inv
         assign sel = ~word_i;
      end else begin : g_dir
         assign sel = word_i;
      end
   endgenerate

   assign half_o  = HW'(BASE_MIN_HALF) + HW'(sel[STEP_BITS-1:0]);
   assign shift_o = sel[CW-1:STEP_BITS];
endmodule

// File: rtl/pfm_prescaler.sv
module pfm_prescaler #(
   parameter int DIV_BITS = 2,
   localparam int PW = (2 ** DIV_BITS) - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic [DIV_BITS-1:0] shift_i,
   output logic                tick_o
);
   logic [PW-1:0] cnt;
   logic [PW:0]   one_sh;
   logic [PW-1:0] mask;

   assign one_sh = {{PW{1'b0}}, 1'b1} << shift_i;
   assign mask   = PW'(one_sh - 1'b1);
   assign tick_o = (cnt == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr_i || tick_o) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pfm_half_timer.sv
module pfm_half_timer #(
   parameter int HW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          tick_i,
   input  logic [HW-1:0] half_i,
   output logic          last_o
);
   logic [HW-1:0] step;

   assign last_o = tick_i && (step == (half_i - HW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
      end else if (clr_i) begin
         step <= '0;
      end else if (tick_i) begin
         step <= step + 1'b1;
      end
   end
endmodule

// File: rtl/pfm_gate_timer.sv
module pfm_gate_timer
   import pfm_pkg::*;
#(
   parameter int STEP_BITS     = 2,
   parameter int DIV_BITS      = 2,
   parameter int BASE_MIN_HALF = 4,
   parameter bit INVERT        = 1'b1,
   localparam int CW = STEP_BITS + DIV_BITS,
   localparam int HW = $clog2(BASE_MIN_HALF + (2 ** STEP_BITS))
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [CW-1:0] ctrl,
   output logic          lo_gate,
   output logic          hi_gate_n,
   output logic          cyc_done
);
   generate
      if (BASE_MIN_HALF < 2) begin : g_bad_base
         $fatal(1, "BASE_MIN_HALF must be at least 2");
      end
      if (STEP_BITS < 1 || DIV_BITS < 1) begin : g_bad_bits
         $fatal(1, "STEP_BITS and DIV_BITS must be at least 1");
      end
   endgenerate

   phase_t              ph;
   logic [HW-1:0]       half_d, half_q;
   logic [DIV_BITS-1:0] shift_d, shift_q;
   logic                tick, last, clr, start, hi_act, done_q;

   pfm_word_decode #(
      .STEP_BITS    (STEP_BITS),
      .DIV_BITS     (DIV_BITS),
      .BASE_MIN_HALF(BASE_MIN_HALF),
      .INVERT       (INVERT)
   ) u_dec (
      .word_i (ctrl),
      .half_o (half_d),
      .shift_o(shift_d)
   );

   assign clr   = (ph == PH_IDLE) || last;
   assign start = req && ((ph == PH_IDLE) || ((ph == PH_OFF) && last));

   pfm_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .shift_i(shift_q),
      .tick_o (tick)
   );

   pfm_half_timer #(.HW(HW)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .tick_i(tick),
      .half_i(half_q),
      .last_o(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= HW'(BASE_MIN_HALF);
         shift_q <= '0;
      end else if (start) begin
         half_q  <= half_d;
         shift_q <= shift_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE;
      end else begin
         unique case (ph)
            PH_IDLE: if (req)  ph <= PH_ON;
            PH_ON:   if (last) ph <= PH_OFF;
            PH_OFF:  if (last) ph <= req ? PH_ON : PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_act <= 1'b0;
         done_q <= 1'b0;
      end else begin
         hi_act <= (ph == PH_ON) && last;
         done_q <= hi_act;
      end
   end

   assign lo_gate   = (ph == PH_ON);
   assign hi_gate_n = ~hi_act;
   assign cyc_done  = done_q;
endmodule

// File: rtl/pfm_gate_timer_chk.sv
module pfm_gate_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic lo_gate,
   input logic hi_gate_n,
   input logic cyc_done
);
   p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo_gate && !hi_gate_n));

   p_hi_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lo_gate) |-> !hi_gate_n);

   p_hi_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_gate_n |=> hi_gate_n);

   p_hi_needs_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_gate_n |-> $past(lo_gate));

   p_done_after_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_gate_n |=> cyc_done);

   p_done_only_after_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> $past(!hi_gate_n));

   p_start_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_gate) |-> $past(req));
endmodule

bind pfm_gate_timer pfm_gate_timer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .lo_gate  (lo_gate),
   .hi_gate_n(hi_gate_n),
   .cyc_done (cyc_done)
);

// File: tb/pfm_gate_timer_bench.sv
module pfm_gate_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [3:0] ctrl = 4'd0;
   logic       lo_gate, hi_gate_n, cyc_done;
   int         total = 0;
   int         bad = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   pfm_gate_timer u_pfm_gate_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .ctrl     (ctrl),
      .lo_gate  (lo_gate),
      .hi_gate_n(hi_gate_n),
      .cyc_done (cyc_done)
   );

   // {control word, expected on-time in clocks}
   localparam logic [9:0] VEC [10] = '{
      {4'd15, 6'd4},  {4'd14, 6'd5},  {4'd13, 6'd6},  {4'd12, 6'd7},
      {4'd11, 6'd8},  {4'd10, 6'd10}, {4'd7,  6'd16}, {4'd5,  6'd24},
      {4'd3,  6'd32}, {4'd0,  6'd56}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic count_high(output int n);
      n = 0;
      while (lo_gate && n < 300) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input logic [3:0] w, input int exp_on);
      int n, m, n2;
      @(negedge clk);
      ctrl = w;
      req  = 1'b1;
      @(negedge clk);
      chk(lo_gate == 1'b1, "R5 start on first edge with req", int'(lo_gate), 1);
      ctrl = ~w;   // mid-cycle change must not matter (R7)
      count_high(n);
      chk(n == exp_on, $sformatf("R2 R3 R7 on-time word %0d", w), n, exp_on);
      chk(hi_gate_n == 1'b0, "R4 high-side low as low-side falls", int'(hi_gate_n), 0);
      chk(cyc_done == 1'b0, "R8 done not yet", int'(cyc_done), 0);
      ctrl = w;
      m = 1;
      @(negedge clk);
      chk(hi_gate_n == 1'b1, "R4 high-side pulse one clock", int'(hi_gate_n), 1);
      chk(cyc_done == 1'b1, "R8 done after pulse", int'(cyc_done), 1);
      while (!lo_gate && m < 300) begin
         m++;
         @(negedge clk);
         if (m == 2) chk(cyc_done == 1'b0, "R8 done one clock", int'(cyc_done), 0);
      end
      chk(m == exp_on, "R1 off-half equals on-half", m, exp_on);
      req = 1'b0;   // withdraw during second cycle (R6)
      count_high(n2);
      chk(n2 == exp_on, "R6 cycle completes after req drop", n2, exp_on);
      n = 0;
      for (int k = 0; k < 2 * exp_on + 4; k++) begin
         if (lo_gate) n++;
         @(negedge clk);
      end
      chk(n == 0, "R5 no restart with req low", n, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(lo_gate == 1'b0, "R9 reset low-side", int'(lo_gate), 0);
      chk(hi_gate_n == 1'b1, "R9 reset high-side", int'(hi_gate_n), 1);
      chk(cyc_done == 1'b0, "R9 reset done", int'(cyc_done), 0);
      rst_n = 1'b1;
      begin
         int n = 0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (lo_gate || !hi_gate_n) n++;
         end
         chk(n == 0, "R5 idle without req", n, 0);
      end

      for (int i = 0; i < 10; i++) begin
         run_vec(VEC[i][9:6], int'(VEC[i][5:0]));
      end

      // reset in the middle of a long on-half
      @(negedge clk);
      ctrl = 4'd0;
      req  = 1'b1;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(lo_gate == 1'b0, "R9 mid-cycle reset low-side", int'(lo_gate), 0);
      chk(hi_gate_n == 1'b1, "R9 mid-cycle reset high-side", int'(hi_gate_n), 1);
      req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(lo_gate == 1'b0, "R5 idle after reset release", int'(lo_gate), 0);

      // shortest word back to back: verify after reset it still runs
      run_vec(4'd15, 4);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule